// File: doc/BRIEF.md
# Processor Debug Mode Controller

This block decides whether a processor core runs normally or sits frozen in debug mode under a development station's control. Each cycle it receives the exceptions the core recognised, a per-cause enable mask, a global debug-enable input, a machine-check event with the machine-check-enable state bit, and strobes for return-from-interrupt, cause-register read, instruction fetch and load/store. From these it records causes in a cause register and holds the freeze output. It steers fetches either to memory or to the development port. It also issues the strobes that write the save/restore registers, clear the external-interrupt enable bit, and take a normal vectored exception.

From normal mode, an exception whose cause bit is enabled moves the core into debug mode, provided debug is globally enabled. Any other exception is vectored in the normal way. In debug mode, exceptions are only recorded. Each one raises a one-clock error pulse for the development port. Breakpoints and watchpoints are blocked, and the save/restore registers are left alone. A return-from-interrupt strobe leaves debug mode. If an enabled cause is still pending at that strobe, the core re-enters debug mode at once.

Top module: `dbg_mode_ctl`

## Requirements
- R1: After reset, `freeze` and `in_debug` are 0, `cause` is all zero and `err_pulse` is 0.
- R2: In normal mode, a cycle with any exception enters debug mode on the next clock when `dbg_en` is 1 and at least one of that cycle's cause bits has its `evt_en` bit set. In that case `ee_clr` is 1 in the same cycle. Otherwise `vec_take` is 1 in that cycle and the mode stays normal.
- R3: In debug mode, every `fetch_req` gives `fetch_port`=1 and `fetch_mem`=0. In normal mode it gives `fetch_mem`=1 and `fetch_port`=0. `ls_mem` follows `ls_req` in both modes.
- R4: Each exception bit i sets `cause[i]` on the next clock. The `cause_rd` input clears the register on the next clock. A bit whose exception arrives in the same cycle as the read stays set.
- R5: An exception cycle in debug mode drives `err_pulse` to 1 for exactly the following clock. In that exception cycle, `vec_take`, `srr_wr` and `ee_clr` are all 0.
- R6: `srr_wr` is 1 only in a normal-mode exception cycle or in a debug re-entry cycle (R10). It is never 1 for an exception recognised while in debug mode.
- R7: While in debug mode, `bp_out` and `wp_out` are 0 whatever `bp_raw` and `wp_raw` are. In normal mode they follow those inputs.
- R8: `ee_clr` is 1 only in the cycle that enters debug mode, either from normal mode or by re-entry.
- R9: In debug mode, `rfi_stb` with no enabled cause pending drops `freeze` on the next clock. Pending is computed on the cause value after that cycle's read and events. In normal mode, `rfi_stb` has no effect.
- R10: In debug mode, `rfi_stb` with an enabled cause pending keeps `freeze` at 1 and strobes `srr_wr` and `ee_clr` in that cycle.
- R11: When a machine check arrives in normal mode with `msr_me`=1 and `dbg_en`=1, the cause register is loaded with only bit MCK_BIT set. MCK_BIT is 28 by default, which gives value 0x10000000. Debug mode is entered if `evt_en[MCK_BIT]` is 1. Otherwise `vec_take` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_en | input | 1 | Global debug-mode enable |
| exc_evt | input | NCAUSE | Exceptions recognised this cycle, one bit per cause |
| mc_evt | input | 1 | Machine check recognised this cycle |
| msr_me | input | 1 | Machine-check-enable state bit |
| evt_en | input | NCAUSE | Per-cause enable mask |
| rfi_stb | input | 1 | Return-from-interrupt strobe |
| cause_rd | input | 1 | Development port reads (and clears) the cause register |
| fetch_req | input | 1 | Instruction fetch strobe |
| ls_req | input | 1 | Load/store strobe |
| bp_raw | input | 1 | Breakpoint match from comparators |
| wp_raw | input | 1 | Watchpoint match from comparators |
| in_debug | output | 1 | Current mode status (1 = debug) |
| freeze | output | 1 | Freeze indication |
| err_pulse | output | 1 | One-clock notice of an exception in debug mode |
| cause | output | NCAUSE | Cause register contents |
| vec_take | output | 1 | Take a normal vectored exception |
| srr_wr | output | 1 | Write the save/restore registers |
| ee_clr | output | 1 | Clear the external-interrupt enable bit |
| fetch_port | output | 1 | Fetch served by the development port |
| fetch_mem | output | 1 | Fetch served by memory |
| ls_mem | output | 1 | Load/store served by memory |
| bp_out | output | 1 | Gated breakpoint |
| wp_out | output | 1 | Gated watchpoint |

## Verification
The bench uses a 4-cause configuration. It sweeps every exception pattern against every enable mask, with the global enable both off and on. This separates entry into debug mode from normal vectoring, and it catches the case where a raised cause is masked out. From every state reached in debug mode, the bench follows with a second exception on the remaining bits. It then sends a return strobe while a cause is still pending, and another return strobe combined with a read. These separate recording-only behaviour, re-entry and a clean exit. Machine checks are tried with the cause bit enabled and disabled, over a non-empty cause register, to show that the register is loaded rather than merged. A read that coincides with a new event shows that the new event survives.

// File: rtl/dbg_mode_ctl.sv
module dbg_mode_ctl #(
  parameter int NCAUSE  = 32,
  parameter int MCK_BIT = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_en,
  input  logic [NCAUSE-1:0] exc_evt,
  input  logic              mc_evt,
  input  logic              msr_me,
  input  logic [NCAUSE-1:0] evt_en,
  input  logic              rfi_stb,
  input  logic              cause_rd,
  input  logic              fetch_req,
  input  logic              ls_req,
  input  logic              bp_raw,
  input  logic              wp_raw,
  output logic              in_debug,
  output logic              freeze,
  output logic              err_pulse,
  output logic [NCAUSE-1:0] cause,
  output logic              vec_take,
  output logic              srr_wr,
  output logic              ee_clr,
  output logic              fetch_port,
  output logic              fetch_mem,
  output logic              ls_mem,
  output logic              bp_out,
  output logic              wp_out
);

  localparam logic [NCAUSE-1:0] MCK_MASK = NCAUSE'(1) << MCK_BIT;

  logic              dbg_q, err_q;
  logic [NCAUSE-1:0] cause_q, cause_nxt, evt_all, kept;
  logic              hit, mc_load, trig, enter_n, pend, reenter, leave;

  assign evt_all = exc_evt | (mc_evt ? MCK_MASK : '0);
  assign hit     = |evt_all;
  assign mc_load = ~dbg_q & mc_evt & msr_me & dbg_en;
  assign kept    = cause_rd ? '0 : cause_q;

  assign cause_nxt = mc_load ? MCK_MASK : (kept | evt_all);

  assign trig    = mc_load ? evt_en[MCK_BIT] : |(evt_all & evt_en);
  assign enter_n = ~dbg_q & hit & dbg_en & trig;
  assign pend    = |(cause_nxt & evt_en);
  assign reenter = dbg_q & rfi_stb & pend;
  assign leave   = dbg_q & rfi_stb & ~pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dbg_q   <= 1'b0;
      err_q   <= 1'b0;
      cause_q <= '0;
    end else begin
      dbg_q   <= enter_n | (dbg_q & ~leave);
      err_q   <= dbg_q & hit;
      cause_q <= cause_nxt;
    end
  end

  assign in_debug   = dbg_q;
  assign freeze     = dbg_q;
  assign err_pulse  = err_q;
  assign cause      = cause_q;
  assign vec_take   = ~dbg_q & hit & ~enter_n;
  assign srr_wr     = (~dbg_q & hit) | reenter;
  assign ee_clr     = enter_n | reenter;
  assign fetch_port = fetch_req & dbg_q;
  assign fetch_mem  = fetch_req & ~dbg_q;
  assign ls_mem     = ls_req;
  assign bp_out     = bp_raw & ~dbg_q;
  assign wp_out     = wp_raw & ~dbg_q;

endmodule

// File: rtl/dbg_mode_ctl_chk.sv
module dbg_mode_ctl_chk #(
  parameter int NCAUSE = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCAUSE-1:0] exc_evt,
  input logic              mc_evt,
  input logic              rfi_stb,
  input logic              fetch_req,
  input logic              freeze,
  input logic              err_pulse,
  input logic              vec_take,
  input logic              srr_wr,
  input logic              ee_clr,
  input logic              fetch_port,
  input logic              fetch_mem,
  input logic              bp_out,
  input logic              wp_out
);

  // R3
  fetch_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> (fetch_port == freeze) && (fetch_mem == !freeze));

  // R5
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(freeze && ((|exc_evt) || mc_evt)));

  // R6
  srr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !rfi_stb) |-> !srr_wr);

  // R7
  bp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (!bp_out && !wp_out));

  // R8
  ee_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(freeze) |-> $past(ee_clr));

  // R9
  rfi_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && rfi_stb && !ee_clr) |=> !freeze);

  // R2
  vec_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |-> (!freeze && !ee_clr));

endmodule

bind dbg_mode_ctl dbg_mode_ctl_chk #(.NCAUSE(NCAUSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .exc_evt(exc_evt), .mc_evt(mc_evt),
  .rfi_stb(rfi_stb), .fetch_req(fetch_req), .freeze(freeze),
  .err_pulse(err_pulse), .vec_take(vec_take), .srr_wr(srr_wr),
  .ee_clr(ee_clr), .fetch_port(fetch_port), .fetch_mem(fetch_mem),
  .bp_out(bp_out), .wp_out(wp_out)
);

// File: tb/sim_dbg_mode_ctl.sv
`timescale 1ns/1ps
module sim_dbg_mode_ctl;
  localparam int N  = 4;
  localparam int MB = 2;

  logic clk = 1'b0;
  logic rst_n, dbg_en, mc_evt, msr_me, rfi_stb, cause_rd;
  logic fetch_req, ls_req, bp_raw, wp_raw;
  logic [N-1:0] exc_evt, evt_en;
  logic in_debug, freeze, err_pulse, vec_take, srr_wr, ee_clr;
  logic fetch_port, fetch_mem, ls_mem, bp_out, wp_out;
  logic [N-1:0] cause;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dbg_mode_ctl #(.NCAUSE(N), .MCK_BIT(MB)) u0 (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .exc_evt(exc_evt),
    .mc_evt(mc_evt), .msr_me(msr_me), .evt_en(evt_en), .rfi_stb(rfi_stb),
    .cause_rd(cause_rd), .fetch_req(fetch_req), .ls_req(ls_req),
    .bp_raw(bp_raw), .wp_raw(wp_raw), .in_debug(in_debug), .freeze(freeze),
    .err_pulse(err_pulse), .cause(cause), .vec_take(vec_take),
    .srr_wr(srr_wr), .ee_clr(ee_clr), .fetch_port(fetch_port),
    .fetch_mem(fetch_mem), .ls_mem(ls_mem), .bp_out(bp_out), .wp_out(wp_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    exc_evt = '0; mc_evt = 0; rfi_stb = 0; cause_rd = 0;
    fetch_req = 0; ls_req = 0; bp_raw = 0; wp_raw = 0;
  endtask

  task automatic do_reset();
    quiet();
    rst_n = 0;
    tick();
    rst_n = 1;
    #1;
    chk("R1 freeze", freeze, 0);
    chk("R1 in_debug", in_debug, 0);
    chk("R1 cause", cause, 0);
    chk("R1 err", err_pulse, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 0; dbg_en = 0; msr_me = 0; evt_en = '0;
    quiet();
    @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      for (int e = 1; e < 16; e++) begin
        for (int m = 0; m < 16; m++) begin
          logic ent;
          logic [N-1:0] e2;
          do_reset();
          ent = (d == 1) && ((e & m) != 0);
          e2 = ~N'(e);
          dbg_en = d[0]; evt_en = N'(m); exc_evt = N'(e);
          #1;
          chk("R2 ee_clr", ee_clr, ent);
          chk("R2 vec_take", vec_take, !ent);
          chk("R6 srr normal", srr_wr, 1);
          tick();
          exc_evt = '0;
          #1;
          chk("R2 freeze", freeze, ent);
          chk("R4 cause", cause, e);
          chk("R5 no err normal", err_pulse, 0);
          if (ent) begin
            fetch_req = 1; ls_req = 1; bp_raw = 1; wp_raw = 1;
            #1;
            chk("R3 port", fetch_port, 1);
            chk("R3 mem", fetch_mem, 0);
            chk("R3 ls", ls_mem, 1);
            chk("R7 bp", bp_out, 0);
            chk("R7 wp", wp_out, 0);
            quiet();
            exc_evt = e2;
            #1;
            if (e2 != 0) begin
              chk("R6 srr debug", srr_wr, 0);
              chk("R5 vec", vec_take, 0);
              chk("R8 ee debug", ee_clr, 0);
            end
            tick();
            exc_evt = '0;
            #1;
            chk("R5 err", err_pulse, e2 != 0);
            chk("R4 cause debug", cause, 4'hF);
            chk("R5 freeze held", freeze, 1);
            tick();
            #1;
            chk("R5 err one clock", err_pulse, 0);
            rfi_stb = 1;
            #1;
            chk("R10 srr", srr_wr, 1);
            chk("R10 ee", ee_clr, 1);
            tick();
            rfi_stb = 0;
            #1;
            chk("R10 freeze", freeze, 1);
            rfi_stb = 1; cause_rd = 1;
            #1;
            chk("R4 read data", cause, 4'hF);
            chk("R9 no srr", srr_wr, 0);
            tick();
            quiet();
            #1;
            chk("R9 exit", freeze, 0);
            chk("R4 cleared", cause, 0);
          end else begin
            fetch_req = 1; ls_req = 1; bp_raw = 1; wp_raw = 1;
            #1;
            chk("R3 mem normal", fetch_mem, 1);
            chk("R3 port normal", fetch_port, 0);
            chk("R7 bp normal", bp_out, 1);
            chk("R7 wp normal", wp_out, 1);
            quiet();
            rfi_stb = 1;
            tick();
            quiet();
            #1;
            chk("R9 rfi normal", freeze, 0);
            chk("R9 cause kept", cause, e);
          end
        end
      end
    end

    // R4: read and new event in the same cycle
    do_reset();
    dbg_en = 0; exc_evt = 4'b0001;
    tick();
    exc_evt = 4'b0010; cause_rd = 1;
    tick();
    quiet();
    #1;
    chk("R4 read+event", cause, 4'b0010);

    // R11: machine check, enable bit set and clear
    for (int b = 0; b < 2; b++) begin
      do_reset();
      dbg_en = 0; exc_evt = 4'b0001;
      tick();
      quiet();
      dbg_en = 1; msr_me = 1; evt_en = b[0] ? 4'b0100 : 4'b1011; mc_evt = 1;
      #1;
      chk("R11 vec", vec_take, !b[0]);
      chk("R11 ee", ee_clr, b[0]);
      tick();
      quiet();
      #1;
      chk("R11 cause load", cause, 4'b0100);
      chk("R11 freeze", freeze, b[0]);
    end
    msr_me = 0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule